// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block gathers the interrupt sources of a UART into one 8-bit status word and drives an active-low interrupt request line. Two of the status bits are sticky event flags that only a command can clear:
- a change on the multipurpose input pin;
- the start or end of a received break.

One bit holds a snapshot of that pin's level. It is taken when a status read begins.

Four bits are registered copies of live levels from the neighbouring logic:
- counter ready;
- receiver ready or FIFO full;
- transmitter empty;
- transmitter ready.

An 8-bit mask register selects which status bits may pull the interrupt line low. The status word is always read back unmasked. The sources themselves and the bus address decoding sit outside the block. A bus front end drives the write strobe, the two clear commands and the read-start pulse.

Top module: `uart_irq_status`

## Requirements
- R1: `irq_n` is 0 exactly when at least one bit position is 1 in both `stat_rdata` and `mask_rdata`, in the same cycle, with the default `IRQ_REG = 0`. Otherwise it is 1.
- R2: `stat_rdata` shows the true status whatever `mask_rdata` holds. A status bit whose mask bit is 0 still reads as 1.
- R3: While `rst_n` is low, `stat_rdata` is 0x00, `mask_rdata` is 0x00 and `irq_n` is 1. A reset in mid-run clears the sticky bits 7 and 3.
- R4: Bit 7 sets when a change of `mpi_pin` passes through the 2-flop synchroniser. It is visible after the third rising edge that follows the change. It then stays 1 until a cycle with `clr_mpi_chg` high. A change detection and a clear in the same cycle leave the bit at 1.
- R5: Bit 6 takes the synchronised `mpi_pin` level at each rising edge where `stat_rd_start` is 1. It keeps that value at every other edge, even if the pin moves.
- R6: Bit 3 sets on the edge after `brk_edge_evt` is 1. It stays 1 until a cycle with `clr_brk_chg` high clears it. If both are high in the same cycle, the bit stays 1.
- R7: The mirror bits show, one edge after sampling, the following inputs:
  - bit 4: `cnt_rdy`;
  - bit 2: `rx_rdy_full`;
  - bit 1: `tx_empty`;
  - bit 0: `tx_rdy`.
- R8: Bit 5 of `stat_rdata` always reads 0. Setting mask bit 5 never pulls `irq_n` low.
- R9: A cycle with `mask_wr_en` high loads `mask_wr_data` into the mask register. The new value is on `mask_rdata` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, synchronous deassertion |
| mpi_pin | input | 1 | Asynchronous multipurpose input pin |
| brk_edge_evt | input | 1 | One-cycle pulse at the start or end of a break |
| cnt_rdy | input | 1 | Counter ready level |
| rx_rdy_full | input | 1 | Receiver ready or FIFO full level |
| tx_empty | input | 1 | Transmitter empty level |
| tx_rdy | input | 1 | Transmitter ready level |
| clr_mpi_chg | input | 1 | Command that clears status bit 7 |
| clr_brk_chg | input | 1 | Command that clears status bit 3 |
| stat_rd_start | input | 1 | Pulse at the leading edge of a status read |
| mask_wr_en | input | 1 | Mask register write strobe |
| mask_wr_data | input | 8 | Mask write data |
| stat_rdata | output | 8 | Unmasked status word |
| mask_rdata | output | 8 | Current mask register |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that `brk_edge_evt`, the clear commands and `stat_rd_start` are synchronous to `clk`. They also assume that `mpi_pin` is low when reset is released, since the edge detector's history flop resets to 0. The stimulus changes every input just after a falling edge and holds the pin low through each reset. The bench schedules the pin changes so that the change detection inside the synchroniser lines up with a clear command. This exercises the rule that a set wins over a clear.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int unsigned STAT_W      = 8;
   localparam int unsigned POS_MPI_CHG = 7;
   localparam int unsigned POS_MPI_LVL = 6;
   localparam int unsigned POS_SPARE   = 5;
   localparam int unsigned POS_CNT     = 4;
   localparam int unsigned POS_BRK     = 3;
   localparam int unsigned POS_RX      = 2;
   localparam int unsigned POS_TXE     = 1;
   localparam int unsigned POS_TXR     = 0;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic lvl_o,
   output logic chg_o
);
   localparam int unsigned TOP = STAGES - 1;

   logic [STAGES-1:0] chain_q;
   logic              hist_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("irq_pin_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= pin_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= 1'b0;
      else        hist_q <= chain_q[TOP];
   end

   assign lvl_o = chain_q[TOP];
   assign chg_o = chain_q[TOP] ^ hist_q;
endmodule

// File: rtl/irq_sticky_flag.sv
module irq_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int unsigned       W       = 8,
   parameter logic [W-1:0]      RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en_i,
   input  logic [W-1:0] wr_data_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q_o <= RST_VAL;
      else if (wr_en_i) q_o <= wr_data_i;
   end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
   import uart_irq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          IRQ_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mpi_pin,
   input  logic              brk_edge_evt,
   input  logic              cnt_rdy,
   input  logic              rx_rdy_full,
   input  logic              tx_empty,
   input  logic              tx_rdy,
   input  logic              clr_mpi_chg,
   input  logic              clr_brk_chg,
   input  logic              stat_rd_start,
   input  logic              mask_wr_en,
   input  logic [STAT_W-1:0] mask_wr_data,
   output logic [STAT_W-1:0] stat_rdata,
   output logic [STAT_W-1:0] mask_rdata,
   output logic              irq_n
);
   localparam int unsigned N_MIRROR = 4;
   localparam int unsigned MIRROR_POS [N_MIRROR] = '{POS_CNT, POS_RX, POS_TXE, POS_TXR};

   logic                sync_lvl, sync_chg;
   logic                mpi_chg_q, brk_chg_q, mpi_lvl_q;
   logic [N_MIRROR-1:0] mir_d, mir_q;
   logic [STAT_W-1:0]   stat_w, hit_w;

   irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(mpi_pin), .lvl_o(sync_lvl), .chg_o(sync_chg)
   );

   irq_sticky_flag u_mpi_flag (
      .clk(clk), .rst_n(rst_n), .set_i(sync_chg), .clr_i(clr_mpi_chg), .q_o(mpi_chg_q)
   );

   irq_sticky_flag u_brk_flag (
      .clk(clk), .rst_n(rst_n), .set_i(brk_edge_evt), .clr_i(clr_brk_chg), .q_o(brk_chg_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             mpi_lvl_q <= 1'b0;
      else if (stat_rd_start) mpi_lvl_q <= sync_lvl;
   end

   assign mir_d = {cnt_rdy, rx_rdy_full, tx_empty, tx_rdy};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mir_q <= '0;
      else        mir_q <= mir_d;
   end

   irq_mask_reg #(.W(STAT_W), .RST_VAL('0)) u_mask (
      .clk(clk), .rst_n(rst_n), .wr_en_i(mask_wr_en), .wr_data_i(mask_wr_data), .q_o(mask_rdata)
   );

   always_comb begin
      stat_w              = '0;
      stat_w[POS_MPI_CHG] = mpi_chg_q;
      stat_w[POS_MPI_LVL] = mpi_lvl_q;
      stat_w[POS_BRK]     = brk_chg_q;
      for (int i = 0; i < N_MIRROR; i++) begin
         stat_w[MIRROR_POS[i]] = mir_q[N_MIRROR-1-i];
      end
      stat_w[POS_SPARE]   = 1'b0;
   end

   assign stat_rdata = stat_w;
   assign hit_w      = stat_w & mask_rdata;

   generate
      if (IRQ_REG) begin : g_irq_ff
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_n <= 1'b1;
            else        irq_n <= ~|hit_w;
         end
      end else begin : g_irq_comb
         assign irq_n = ~|hit_w;
      end
   endgenerate
endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk #(
   parameter bit IRQ_REG = 1'b0
) (
   input logic       clk,
   input logic       rst_n,
   input logic       brk_edge_evt,
   input logic       cnt_rdy,
   input logic       tx_rdy,
   input logic       clr_mpi_chg,
   input logic       clr_brk_chg,
   input logic       stat_rd_start,
   input logic       mask_wr_en,
   input logic [7:0] mask_wr_data,
   input logic [7:0] stat_rdata,
   input logic [7:0] mask_rdata,
   input logic       irq_n
);
   generate
      if (!IRQ_REG) begin : g_comb
         AST_IRQ_ASSERTED: assert property (@(posedge clk) disable iff (!rst_n)
            (|(stat_rdata & mask_rdata)) |-> !irq_n); // R1
         AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !(|(stat_rdata & mask_rdata)) |-> irq_n); // R1
      end
   endgenerate

   AST_MPI_CHG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rdata[7] && !clr_mpi_chg) |=> stat_rdata[7]); // R4
   AST_MPI_LVL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_rd_start |=> $stable(stat_rdata[6])); // R5
   AST_BRK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      brk_edge_evt |=> stat_rdata[3]); // R6
   AST_BRK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rdata[3] && !clr_brk_chg) |=> stat_rdata[3]); // R6
   AST_MIRROR_CNT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (stat_rdata[4] == $past(cnt_rdy))); // R7
   AST_MIRROR_TXR: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (stat_rdata[0] == $past(tx_rdy))); // R7
   AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      mask_rdata[5] |-> !stat_rdata[5]); // R8
   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr_en |=> (mask_rdata == $past(mask_wr_data))); // R9
endmodule

bind uart_irq_status uart_irq_status_chk #(.IRQ_REG(IRQ_REG)) chk_i (
   .clk(clk), .rst_n(rst_n), .brk_edge_evt(brk_edge_evt), .cnt_rdy(cnt_rdy),
   .tx_rdy(tx_rdy), .clr_mpi_chg(clr_mpi_chg), .clr_brk_chg(clr_brk_chg),
   .stat_rd_start(stat_rd_start), .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
   .stat_rdata(stat_rdata), .mask_rdata(mask_rdata), .irq_n(irq_n)
);

// File: tb/uart_irq_status_tb_top.sv
module uart_irq_status_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mpi_pin = 1'b0, brk_edge_evt = 1'b0;
   logic       cnt_rdy = 1'b0, rx_rdy_full = 1'b0, tx_empty = 1'b0, tx_rdy = 1'b0;
   logic       clr_mpi_chg = 1'b0, clr_brk_chg = 1'b0, stat_rd_start = 1'b0;
   logic       mask_wr_en = 1'b0;
   logic [7:0] mask_wr_data = '0;
   logic [7:0] stat_rdata, mask_rdata;
   logic       irq_n;
   int         n_chk = 0, n_bad = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   uart_irq_status dut_i (
      .clk(clk), .rst_n(rst_n), .mpi_pin(mpi_pin), .brk_edge_evt(brk_edge_evt),
      .cnt_rdy(cnt_rdy), .rx_rdy_full(rx_rdy_full), .tx_empty(tx_empty), .tx_rdy(tx_rdy),
      .clr_mpi_chg(clr_mpi_chg), .clr_brk_chg(clr_brk_chg), .stat_rd_start(stat_rd_start),
      .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
      .stat_rdata(stat_rdata), .mask_rdata(mask_rdata), .irq_n(irq_n)
   );

   // vector: mask[20:13], sources {cnt,rx,txe,txr}[12:9], expected status[8:1], expected irq_n[0]
   localparam int NVEC = 8;
   localparam logic [20:0] VEC [NVEC] = '{
      {8'h00, 4'b1111, 8'h17, 1'b1},
      {8'h01, 4'b0001, 8'h01, 1'b0},
      {8'hFE, 4'b0001, 8'h01, 1'b1},
      {8'h10, 4'b1000, 8'h10, 1'b0},
      {8'h04, 4'b0100, 8'h04, 1'b0},
      {8'h02, 4'b0100, 8'h04, 1'b1},
      {8'h20, 4'b1111, 8'h17, 1'b1},
      {8'hFF, 4'b0000, 8'h00, 1'b1}
   };

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R3 stat in reset", stat_rdata, 8'h00);
      chk("R3 mask in reset", mask_rdata, 8'h00);
      chk("R3 irq_n in reset", {7'd0, irq_n}, 8'h01);
      rst_n = 1'b1;
      step();

      // table: R1, R2, R7, R8, R9
      for (int v = 0; v < NVEC; v++) begin
         mask_wr_en = 1'b1;
         mask_wr_data = VEC[v][20:13];
         {cnt_rdy, rx_rdy_full, tx_empty, tx_rdy} = VEC[v][12:9];
         step();
         mask_wr_en = 1'b0;
         chk("R9 mask readback", mask_rdata, VEC[v][20:13]);
         chk("R7/R2/R8 status", stat_rdata, VEC[v][8:1]);
         chk("R1 irq_n", {7'd0, irq_n}, {7'd0, VEC[v][0]});
      end
      {cnt_rdy, rx_rdy_full, tx_empty, tx_rdy} = 4'b0000;
      mask_wr_en = 1'b1; mask_wr_data = 8'h80;
      step();
      mask_wr_en = 1'b0;

      // R4 change latency and stickiness
      mpi_pin = 1'b1;
      step(); step();
      chk("R4 not yet after 2 edges", {7'd0, stat_rdata[7]}, 8'h00);
      step();
      chk("R4 set after 3 edges", {7'd0, stat_rdata[7]}, 8'h01);
      chk("R1 irq on mpi change", {7'd0, irq_n}, 8'h00);
      step(); step();
      chk("R4 sticky", {7'd0, stat_rdata[7]}, 8'h01);
      chk("R5 level not sampled without read", {7'd0, stat_rdata[6]}, 8'h00);
      clr_mpi_chg = 1'b1; step(); clr_mpi_chg = 1'b0;
      chk("R4 cleared by command", {7'd0, stat_rdata[7]}, 8'h00);
      chk("R1 irq released", {7'd0, irq_n}, 8'h01);

      // R5 snapshot
      stat_rd_start = 1'b1; step(); stat_rd_start = 1'b0;
      chk("R5 level captured high", {7'd0, stat_rdata[6]}, 8'h01);

      // R4 set wins: change reaches detector at 3rd edge, clear held for that edge
      mpi_pin = 1'b0;
      step(); step();
      clr_mpi_chg = 1'b1; step(); clr_mpi_chg = 1'b0;
      chk("R4 set wins over clear", {7'd0, stat_rdata[7]}, 8'h01);
      step();
      chk("R5 level held while pin low", {7'd0, stat_rdata[6]}, 8'h01);
      stat_rd_start = 1'b1; step(); stat_rd_start = 1'b0;
      chk("R5 level captured low", {7'd0, stat_rdata[6]}, 8'h00);
      clr_mpi_chg = 1'b1; step(); clr_mpi_chg = 1'b0;

      // R6 break change flag
      mask_wr_en = 1'b1; mask_wr_data = 8'h08; step(); mask_wr_en = 1'b0;
      brk_edge_evt = 1'b1; step(); brk_edge_evt = 1'b0;
      chk("R6 break set", {7'd0, stat_rdata[3]}, 8'h01);
      chk("R1 irq on break", {7'd0, irq_n}, 8'h00);
      step(); step();
      chk("R6 break sticky", {7'd0, stat_rdata[3]}, 8'h01);
      clr_brk_chg = 1'b1; step(); clr_brk_chg = 1'b0;
      chk("R6 break cleared", {7'd0, stat_rdata[3]}, 8'h00);
      brk_edge_evt = 1'b1; clr_brk_chg = 1'b1; step();
      brk_edge_evt = 1'b0; clr_brk_chg = 1'b0;
      chk("R6 set wins over clear", {7'd0, stat_rdata[3]}, 8'h01);

      // R8 spare bit with mask bit 5 only
      mask_wr_en = 1'b1; mask_wr_data = 8'h20; step(); mask_wr_en = 1'b0;
      chk("R8 spare bit zero", {7'd0, stat_rdata[5]}, 8'h00);
      chk("R8 spare mask no irq", {7'd0, irq_n}, 8'h01);

      // R3 mid-run reset clears sticky bit
      rst_n = 1'b0; step();
      chk("R3 sticky cleared by reset", stat_rdata, 8'h00);
      chk("R3 mask cleared by reset", mask_rdata, 8'h00);
      rst_n = 1'b1; step();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule